// File: doc/BRIEF.md
# Programmable Sample-Window Timer

This block sets how long a converter stays in its sampling phase. A start pulse loads a cycle count, and a sample-active output stays high for exactly that many base-clock cycles. The count is the product of a power-of-two divide value and a multiplier. The divide value comes from a 3-bit divider code. The multiplier comes from one of two 10-bit compare registers, and a select input picks which one for each conversion.

Software programs the two compare registers and the divider code through a small register port. The port has a write strobe, a 2-bit address and write data, plus a combinational read-back of the addressed register. While the conversion-enable input is high, the compare registers cannot be written. A done pulse marks the last cycle of each window. A start pulse that arrives while a window is still running is dropped, and the block reports it with a one-cycle overflow strobe.

Top module: `sample_window_timer`

## Requirements
- R1: After a synchronous active-low reset, both compare registers and the divider code are 0. Read-back of every address is 0, and the active, done and overflow outputs are low.
- R2: Address 0 selects compare register 0, address 1 selects compare register 1, address 2 selects the divider code (bits 2..0) and address 3 reads 0. A compare register stores write data bits 9..0, and its read-back bits 31..10 are always 0.
- R3: The divide value is 2 raised to the divider code, which gives 1 to 128. Code 2 gives 4.
- R4: When the selected compare value is 0 or 1, the window lasts one divide value of base-clock cycles.
- R5: When the selected compare value is greater than 1, the window lasts that value times the divide value. Code 3 with value 4 gives 32 cycles.
- R6: The select input, sampled with the start pulse, picks compare register 0 when it is 0 and compare register 1 when it is 1.
- R7: A write to either compare register is ignored while conversion-enable is 1. Writes to the divider code are accepted at any time.
- R8: Active rises in the cycle after a start pulse that finds the block idle. It then stays high for exactly the window length.
- R9: Done is high for exactly one cycle per window, in the last active cycle. Active is low in the cycle after done.
- R10: A start pulse that arrives while active is high does not change the running window. It causes the overflow output to be high for one cycle, in the cycle after that pulse.
- R11: The window length is captured at the start pulse. Changing the select input or the divider code during a window does not change that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for both write and read-back |
| cfg_wdata | input | 10 | Register write data |
| cfg_rdata | output | 32 | Read-back of the addressed register |
| conv_en | input | 1 | Conversion enable; locks the compare registers while high |
| start | input | 1 | One-cycle request to open a sampling window |
| sel | input | 1 | Selects compare register 0 or 1 for the window being started |
| active | output | 1 | High during the sampling window |
| done | output | 1 | One-cycle pulse in the last window cycle |
| overflow | output | 1 | One-cycle strobe after a start pulse that was dropped |

## Verification
The hardest conditions to create are a start pulse, or a change to the select input or divider code, that lands in the middle of a running window. Both must leave the window length unchanged. The bench walks each window one cycle at a time at the falling edge and counts the active cycles. It injects the extra start pulse or the configuration change at a chosen count, then checks the total length, the single done position and the timing of the overflow strobe.

// File: rtl/swt_pkg.sv
// Shared definitions for the sample-window timer.
// Assumes the register port uses a 2-bit address.
package swt_pkg;

    // Register addresses of the configuration port
    typedef enum logic [1:0] {
        SWT_ADDR_CMP0 = 2'd0,
        SWT_ADDR_CMP1 = 2'd1,
        SWT_ADDR_DIV  = 2'd2,
        SWT_ADDR_NONE = 2'd3
    } swt_addr_e;

    // Width needed for the longest window: largest multiplier shifted by the largest code
    function automatic int swt_len_width(input int val_w, input int div_w);
        return val_w + (1 << div_w) - 1;
    endfunction

endpackage

// File: rtl/swt_cfg_regs.sv
// Configuration registers: two compare values and the divider code.
// Compare writes are dropped while conversion is enabled; the divider
// code is always writable. Read-back is combinational, reserved bits read 0.
module swt_cfg_regs #(
    parameter int VAL_W  = 10,
    parameter int DIV_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_addr,
    input  logic [VAL_W-1:0]       cfg_wdata,
    input  logic                   conv_en,
    output logic [DATA_W-1:0]      cfg_rdata,
    output logic [1:0][VAL_W-1:0]  cmp_val,
    output logic [DIV_W-1:0]       div_code
);
    import swt_pkg::*;

    localparam int NUM_CMP = 2;

    // One locked compare register per slot
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        // Load the compare value when addressed and not locked
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_val[i] <= '0;
            end else if (cfg_we && !conv_en && cfg_addr == 2'(i)) begin
                cmp_val[i] <= cfg_wdata;
            end
        end
    end

    // Load the divider code whenever addressed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code <= '0;
        end else if (cfg_we && swt_addr_e'(cfg_addr) == SWT_ADDR_DIV) begin
            div_code <= cfg_wdata[DIV_W-1:0];
        end
    end

    // Read-back mux with zero-filled reserved bits
    always_comb begin
        cfg_rdata = '0;
        case (swt_addr_e'(cfg_addr))
            SWT_ADDR_CMP0: cfg_rdata[VAL_W-1:0] = cmp_val[0];
            SWT_ADDR_CMP1: cfg_rdata[VAL_W-1:0] = cmp_val[1];
            SWT_ADDR_DIV:  cfg_rdata[DIV_W-1:0] = div_code;
            default:       cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/swt_len_calc.sv
// Window length calculation: picks a compare value, raises 0 and 1 to 1,
// then shifts by the divider code. Purely combinational.
// Assumes LEN_W holds the largest value shifted by the largest code.
module swt_len_calc #(
    parameter int VAL_W = 10,
    parameter int DIV_W = 3,
    parameter int LEN_W = 17
) (
    input  logic [1:0][VAL_W-1:0] cmp_val,
    input  logic                  sel,
    input  logic [DIV_W-1:0]      div_code,
    output logic [LEN_W-1:0]      win_len
);
    logic [VAL_W-1:0] chosen;
    logic [VAL_W-1:0] mult;

    // Pick the compare value and clamp small values to one period
    always_comb begin
        chosen = sel ? cmp_val[1] : cmp_val[0];
        mult   = (chosen < VAL_W'(2)) ? VAL_W'(1) : chosen;
    end

    // Scale by the power-of-two divide value
    assign win_len = LEN_W'(mult) << div_code;

endmodule

// File: rtl/swt_window_ctr.sv
// Window down-counter. An idle start loads the length. Active holds while
// the count is non-zero, and done marks the final count. A start pulse
// during a window is dropped and flagged one cycle later.
// Assumes load_len is never zero.
module swt_window_ctr #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] load_len,
    output logic             active,
    output logic             done,
    output logic             overflow
);
    logic [LEN_W-1:0] remain;
    logic             ovf_q;

    assign active   = (remain != '0);
    assign done     = (remain == LEN_W'(1));
    assign overflow = ovf_q;

    // Load on an idle start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start && !active) begin
            remain <= load_len;
        end else if (active) begin
            remain <= remain - LEN_W'(1);
        end
    end

    // Flag a start pulse that arrived during a window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= start && active;
        end
    end

endmodule

// File: rtl/sample_window_timer.sv
// Top level of the sample-window timer. Ties the configuration registers,
// the length calculation and the window counter together. Assumes start
// is a single-cycle pulse that is synchronous to clk.
module sample_window_timer #(
    parameter int VAL_W  = 10,
    parameter int DIV_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [VAL_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              conv_en,
    input  logic              start,
    input  logic              sel,
    output logic              active,
    output logic              done,
    output logic              overflow
);
    import swt_pkg::*;

    localparam int LEN_W = swt_len_width(VAL_W, DIV_W);

    logic [1:0][VAL_W-1:0] cmp_val;
    logic [DIV_W-1:0]      div_code;
    logic [LEN_W-1:0]      win_len;

    swt_cfg_regs #(.VAL_W(VAL_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .conv_en   (conv_en),
        .cfg_rdata (cfg_rdata),
        .cmp_val   (cmp_val),
        .div_code  (div_code)
    );

    swt_len_calc #(.VAL_W(VAL_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) i_len (
        .cmp_val  (cmp_val),
        .sel      (sel),
        .div_code (div_code),
        .win_len  (win_len)
    );

    swt_window_ctr #(.LEN_W(LEN_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_len (win_len),
        .active   (active),
        .done     (done),
        .overflow (overflow)
    );

endmodule

// File: rtl/swt_checker.sv
// Temporal checks on the sample-window timer ports, bound to the top level.
module swt_checker #(
    parameter int VAL_W  = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              conv_en,
    input logic              start,
    input logic              active,
    input logic              done,
    input logic              overflow
);
    AST_CMP_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[1] == 1'b0) |-> (cfg_rdata[DATA_W-1:VAL_W] == '0)); // R2

    AST_CMP0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd0 && $past(cfg_addr) == 2'd0 && $past(conv_en && cfg_we))
        |-> (cfg_rdata == $past(cfg_rdata))); // R7

    AST_IDLE_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> active); // R8

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> active); // R8

    AST_DONE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> active); // R9

    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!active && !done)); // R9

    AST_OVERFLOW_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active) |=> overflow); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && active) |=> !overflow); // R10

endmodule

bind sample_window_timer swt_checker #(.VAL_W(VAL_W), .DATA_W(DATA_W)) i_swt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .conv_en   (conv_en),
    .start     (start),
    .active    (active),
    .done      (done),
    .overflow  (overflow)
);

// File: tb/test_sample_window_timer.sv
`timescale 1ns/1ps
module test_sample_window_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [9:0]  cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        conv_en = 1'b0;
    logic        start = 1'b0;
    logic        sel = 1'b0;
    logic        active, done, overflow;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sample_window_timer i_sample_window_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .conv_en(conv_en),
        .start(start), .sel(sel), .active(active), .done(done), .overflow(overflow)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [9:0]  v0;
        logic [9:0]  v1;
        logic        sel;
        logic [16:0] len;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 10'd0,    10'd5, 1'b0, 17'd1},    // R4 value 0
        '{3'd0, 10'd1,    10'd0, 1'b0, 17'd1},    // R4 value 1
        '{3'd2, 10'd1,    10'd0, 1'b0, 17'd4},    // R3 code 2 -> 4
        '{3'd2, 10'd3,    10'd9, 1'b0, 17'd12},   // R5
        '{3'd3, 10'd0,    10'd4, 1'b1, 17'd32},   // R5 R6 code 3 value 4
        '{3'd0, 10'd7,    10'd2, 1'b1, 17'd2},    // R6
        '{3'd1, 10'd1023, 10'd3, 1'b0, 17'd2046}, // R5 largest value
        '{3'd7, 10'd2,    10'd0, 1'b0, 17'd256},  // R3 largest code
        '{3'd5, 10'd0,    10'd1, 1'b1, 17'd32},   // R4 R6
        '{3'd0, 10'd2,    10'd1, 1'b1, 17'd1}     // R6 value 1 on slot 1
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Pulse start, check the rise, then count active cycles and done pulses
    task automatic run_window(output int n, output int dpos, output int dcnt, output bit rose);
        n = 0; dpos = 0; dcnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rose = active;
        while (active) begin
            n++;
            if (done) begin dcnt++; dpos = n; end
            @(negedge clk);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [31:0] r;
        int n, dpos, dcnt, ovf_seen;
        bit rose;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk(r == 0, "R1 readback", r, 0);
        end
        chk({active, done, overflow} == 3'b000, "R1 outputs", {active, done, overflow}, 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            conv_en = 1'b0;
            @(negedge clk);
            wr(2'd0, VECS[i].v0);
            wr(2'd1, VECS[i].v1);
            wr(2'd2, 10'(VECS[i].code));
            conv_en = 1'b1;
            sel = VECS[i].sel;
            @(negedge clk);
            run_window(n, dpos, dcnt, rose);
            chk(rose, "R8 rise after start", rose, 1);
            chk(n == int'(VECS[i].len), "R3 R4 R5 R6 window length", n, VECS[i].len);
            chk(dcnt == 1 && dpos == n, "R9 single done in last cycle", dpos, n);
        end

        // R2 reserved bits and address map
        conv_en = 1'b0;
        @(negedge clk);
        wr(2'd0, 10'h3FF);
        rd(2'd0, r);
        chk(r == 32'h3FF, "R2 compare 0 field", r, 32'h3FF);
        wr(2'd2, 10'h0FF);
        rd(2'd2, r);
        chk(r == 32'd7, "R2 divider field", r, 7);
        rd(2'd3, r);
        chk(r == 0, "R2 unused address", r, 0);

        // R7 lock while enabled
        wr(2'd0, 10'd20);
        wr(2'd1, 10'd33);
        conv_en = 1'b1;
        wr(2'd0, 10'h155);
        wr(2'd1, 10'h2AA);
        rd(2'd0, r);
        chk(r == 20, "R7 compare 0 locked", r, 20);
        rd(2'd1, r);
        chk(r == 33, "R7 compare 1 locked", r, 33);
        wr(2'd2, 10'd0);
        rd(2'd2, r);
        chk(r == 0, "R7 divider writable while enabled", r, 0);

        // R10 start during a window: 20-cycle window, extra start at count 5
        sel = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; dcnt = 0; ovf_seen = 0;
        while (active) begin
            n++;
            if (done) dcnt++;
            if (overflow) ovf_seen++;
            if (n == 6) chk(overflow == 1'b1, "R10 overflow timing", overflow, 1);
            start = (n == 5);
            @(negedge clk);
        end
        start = 1'b0;
        if (overflow) ovf_seen++;
        chk(n == 20, "R10 window unchanged by extra start", n, 20);
        chk(ovf_seen == 1, "R10 single overflow", ovf_seen, 1);
        chk(dcnt == 1, "R10 single done", dcnt, 1);

        // R11 configuration change mid-window: 20 << 1 = 40
        wr(2'd2, 10'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (active) begin
            n++;
            if (n == 3) begin sel = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 10'd5; end
            else cfg_we = 1'b0;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk(n == 40, "R11 length captured at start", n, 40);
        chk(overflow == 1'b0, "R10 no overflow when idle", overflow, 0);

        // R1 reset in the middle of a window
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, r);
        chk(r == 0 && !active, "R1 reset clears window and registers", r, 0);

        summary();
    end

endmodule